// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Sequencer

This block owns the refresh duty for an asynchronous-strobe DRAM. It also brings the memory up after power is applied. Once reset is released it keeps the strobes idle for a programmable start-up pause. It then runs a fixed number of warm-up refresh cycles and raises `ready`, which tells the access controller that normal reads and writes may begin. From then on an interval timer raises a refresh request at a steady rate, sized so that every row is visited within the retention period.

Each refresh goes through the request/grant pair. The sequencer raises `bus_req` and waits for `bus_gnt`. It then drives the strobe and address pins, with `drive_en` high, until the cycle has finished. A build-time parameter selects the refresh method:
- **CAS-before-RAS (CBR):** the DRAM supplies the row internally, and the write strobe is kept high so that the part does not enter test mode.
- **RAS-only:** a wrapping row counter supplies the address, and CAS stays high.

The block watches RAS activity from both itself and the access controller (`ext_ras_n`). If RAS has been inactive for too long, it drops `ready` and repeats the warm-up cycles. A refresh request that stays unserved over several intervals sets `ovr_err`.

The state machine has six states:
- `ST_PAUSE`: the start-up wait.
- `ST_IDLE`: nothing to do.
- `ST_REQ`: bus requested.
- `ST_LEAD`: CAS low ahead of RAS (CBR only).
- `ST_RASLO`: RAS pulse.
- `ST_PRECHG`: RAS precharge.

Its transitions are:
- PAUSE→REQ when the pause ends.
- IDLE→REQ on a pending refresh or outstanding warm-up cycles.
- REQ→LEAD (CBR) or REQ→RASLO (RAS-only) on grant.
- LEAD→RASLO after the lead time.
- RASLO→PRECHG after the pulse width.
- PRECHG→REQ while more than one warm-up cycle remains; otherwise PRECHG→IDLE.

Top module: `dref_seq`

## Requirements
- R1: After reset, `ready`, `bus_req`, `drive_en` and `ovr_err` are low and `ras_n`/`cas_n` are high. No RAS pulse occurs for the first `PAUSE_CYC` cycles.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles complete before `ready` rises. `ready` rises in the cycle after the last precharge, with `bus_req` low.
- R3: `ras_n` or `cas_n` is low only while `bus_req` is high, and only after `bus_gnt` has been seen high. `bus_req` stays high until the precharge of the cycle has finished.
- R4: Every RAS pulse is low for exactly `RAS_LOW_CYC` cycles. It is followed by at least `RAS_PRE_CYC` cycles high before the next pulse.
- R5: In CBR mode (`USE_CBR`=1), `cas_n` is low for at least `CAS_LEAD_CYC` cycles before `ras_n` falls and stays low until `ras_n` rises. `we_n` is high whenever `ras_n` is low.
- R6: In RAS-only mode (`USE_CBR`=0), `cas_n` stays high. `addr` during a pulse is the row counter, which is 0 after reset and increments by one per completed cycle modulo 2^`ROW_W`. `addr` is stable while `ras_n` is low. In CBR mode `addr` is 0.
- R7: After initialisation, with the grant given promptly, one refresh cycle occurs per `INTERVAL_CYC` cycles.
- R8: `ovr_err` goes high once a pending refresh has seen `OVR_LIMIT` further interval ticks without service. It is only high while `bus_req` is high, and it clears when a refresh cycle completes.
- R9: If neither `ras_n` nor `ext_ras_n` is low for `IDLE_LIMIT` cycles, `ready` falls. `INIT_CYCLES` refresh cycles are then run again before `ready` rises.
- R10: A low level on `ext_ras_n` restarts the inactivity count, so an active access controller keeps `ready` high even when refresh grants are withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Grant of the DRAM pins from the access controller |
| ext_ras_n | input | 1 | RAS as driven by the access controller, observed for activity |
| ready | output | 1 | High when initialisation is complete and accesses are allowed |
| bus_req | output | 1 | Request for the DRAM pins |
| drive_en | output | 1 | High while this block drives the DRAM pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr | output | ROW_W | Refresh row address (RAS-only mode), 0 otherwise |
| ovr_err | output | 1 | Refresh request starved for `OVR_LIMIT` intervals |

## Verification
The bench runs a CBR instance and a RAS-only instance side by side under random grant latency. It targets four situations:
- **Warm-up count:** a design that miscounts warm-up cycles raises `ready` after seven or nine pulses.
- **Row counter wrap:** a three-bit row counter wraps during warm-up, and an address that skips or fails to wrap is caught at the next RAS fall.
- **Grant starvation:** grants are withheld long enough first to set the overrun flag and then to expire the inactivity timer. A sequencer that never re-initialises keeps `ready` high, and one that loses the pending request never clears `ovr_err`.
- **Controller activity:** grants are withheld while the controller toggles its own RAS. This exposes a design that ignores `ext_ras_n` and drops `ready` without cause.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_LEAD,
        ST_RASLO,
        ST_PRECHG
    } dref_state_t;

    function automatic int dref_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_tick_gen.sv
module dref_tick_gen #(
    parameter int INTERVAL_CYC = 1560,
    parameter int OVR_LIMIT    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic served,
    output logic pend,
    output logic ovr_err
);
    localparam int CW = $clog2(INTERVAL_CYC);
    localparam int WW = $clog2(OVR_LIMIT + 1);

    logic [CW-1:0] cnt;
    logic [WW-1:0] wait_cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (tick)   pend <= 1'b1;
        else if (served) pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || served)
            wait_cnt <= '0;
        else if (tick && pend && (wait_cnt != WW'(OVR_LIMIT)))
            wait_cnt <= wait_cnt + 1'b1;
    end

    assign ovr_err = (wait_cnt == WW'(OVR_LIMIT));

endmodule

// File: rtl/dref_idle_mon.sv
module dref_idle_mon #(
    parameter int IDLE_LIMIT = 3200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ras_low,
    output logic expire
);
    localparam int CW = $clog2(IDLE_LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || hold || ras_low) cnt <= '0;
        else if (cnt != CW'(IDLE_LIMIT)) cnt <= cnt + 1'b1;
    end

    assign expire = !hold && !ras_low && (cnt == CW'(IDLE_LIMIT - 1));

endmodule

// File: rtl/dref_row_ctr.sv
module dref_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC    = 50000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int IDLE_LIMIT   = 3200000,
    parameter int RAS_LOW_CYC  = 6,
    parameter int RAS_PRE_CYC  = 5,
    parameter int CAS_LEAD_CYC = 1,
    parameter int OVR_LIMIT    = 2,
    parameter int ROW_W        = 11,
    parameter bit USE_CBR      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_gnt,
    input  logic             ext_ras_n,
    output logic             ready,
    output logic             bus_req,
    output logic             drive_en,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr,
    output logic             ovr_err
);
    localparam int PH_MAX = dref_max2(dref_max2(PAUSE_CYC, RAS_LOW_CYC),
                                      dref_max2(RAS_PRE_CYC, CAS_LEAD_CYC));
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int IW     = $clog2(INIT_CYCLES + 1);

    dref_state_t     state, state_nxt;
    logic [PH_W-1:0] ph;
    logic [IW-1:0]   init_left;
    logic            ph_done, cyc_done, pend, idle_exp, ras_seen;
    logic            cas_lead_n;

    assign ph_done  = (ph == '0);
    assign cyc_done = (state == ST_PRECHG) && ph_done;
    assign ras_seen = !ras_n || !ext_ras_n;

    dref_tick_gen #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .OVR_LIMIT   (OVR_LIMIT)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state != ST_PAUSE),
        .served (cyc_done),
        .pend   (pend),
        .ovr_err(ovr_err)
    );

    dref_idle_mon #(
        .IDLE_LIMIT(IDLE_LIMIT)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (state == ST_PAUSE),
        .ras_low(ras_seen),
        .expire (idle_exp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PAUSE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PAUSE:  if (ph_done) state_nxt = ST_REQ;
            ST_IDLE:   if (pend || (init_left != '0)) state_nxt = ST_REQ;
            ST_REQ:    if (bus_gnt) state_nxt = USE_CBR ? ST_LEAD : ST_RASLO;
            ST_LEAD:   if (ph_done) state_nxt = ST_RASLO;
            ST_RASLO:  if (ph_done) state_nxt = ST_PRECHG;
            ST_PRECHG: if (ph_done)
                           state_nxt = (init_left > IW'(1)) ? ST_REQ : ST_IDLE;
            default:   state_nxt = ST_PAUSE;
        endcase
    end

    // Phase timer: loaded on every state change, counts down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_W'(PAUSE_CYC - 1);
        end else if (state_nxt != state) begin
            unique case (state_nxt)
                ST_LEAD:   ph <= PH_W'(CAS_LEAD_CYC - 1);
                ST_RASLO:  ph <= PH_W'(RAS_LOW_CYC - 1);
                ST_PRECHG: ph <= PH_W'(RAS_PRE_CYC - 1);
                default:   ph <= '0;
            endcase
        end else if (!ph_done) begin
            ph <= ph - 1'b1;
        end
    end

    // Warm-up bookkeeping and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_left <= '0;
            ready     <= 1'b0;
        end else if (idle_exp) begin
            init_left <= IW'(INIT_CYCLES);
            ready     <= 1'b0;
        end else begin
            if ((state == ST_PAUSE) && ph_done)
                init_left <= IW'(INIT_CYCLES);
            else if (cyc_done && (init_left != '0))
                init_left <= init_left - 1'b1;
            if (cyc_done && (init_left == IW'(1)))
                ready <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        bus_req    = 1'b0;
        drive_en   = 1'b0;
        ras_n      = 1'b1;
        cas_lead_n = 1'b1;
        we_n       = 1'b1;
        unique case (state)
            ST_REQ:    bus_req = 1'b1;
            ST_LEAD:   begin bus_req = 1'b1; drive_en = 1'b1; cas_lead_n = 1'b0; end
            ST_RASLO:  begin bus_req = 1'b1; drive_en = 1'b1; cas_lead_n = 1'b0; ras_n = 1'b0; end
            ST_PRECHG: begin bus_req = 1'b1; drive_en = 1'b1; end
            default:   ;
        endcase
    end

    generate
        if (USE_CBR) begin : g_cbr
            assign cas_n = cas_lead_n;
            assign addr  = '0;
        end else begin : g_rasonly
            logic [ROW_W-1:0] row;
            dref_row_ctr #(.ROW_W(ROW_W)) u_row (
                .clk  (clk),
                .rst_n(rst_n),
                .inc  (cyc_done),
                .row  (row)
            );
            assign cas_n = 1'b1;
            assign addr  = drive_en ? row : '0;
        end
    endgenerate

endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk #(
    parameter int RAS_LOW_CYC = 6,
    parameter int ROW_W       = 11,
    parameter bit USE_CBR     = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic [ROW_W-1:0] addr,
    input logic             bus_req,
    input logic             ready,
    input logic             ovr_err
);
    localparam int LW = $clog2(RAS_LOW_CYC + 2);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || ras_n)            low_cnt <= '0;
        else if (low_cnt != {LW{1'b1}}) low_cnt <= low_cnt + 1'b1;
    end

    // R3
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_req);

    // R4
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt == LW'(RAS_LOW_CYC)));

    // R2
    ready_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (!bus_req && ras_n));

    // R8
    ovr_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err |-> bus_req);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(addr));

    generate
        if (USE_CBR) begin : g_cbr_chk
            // R5
            cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
            // R5
            cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> !cas_n);
        end else begin : g_ro_chk
            // R6
            cas_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> cas_n);
        end
    endgenerate

endmodule

bind dref_seq dref_seq_chk #(
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .ROW_W      (ROW_W),
    .USE_CBR    (USE_CBR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .addr   (addr),
    .bus_req(bus_req),
    .ready  (ready),
    .ovr_err(ovr_err)
);

// File: tb/sim_dref_seq.sv
module sim_dref_mon #(
    parameter bit CBR  = 1'b1,
    parameter int AW   = 3,
    parameter int LOW  = 6,
    parameter int PRE  = 5,
    parameter int LEAD = 1
) (
    input logic          clk,
    input logic          en,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic          bus_req
);
    int checks = 0, fails = 0, pulses = 0;
    int low_len = 0, high_len = 0, lead = 0, exp_row = 0;
    logic prev_ras = 1'b1;
    logic bad = 1'b0;
    logic [AW-1:0] fall_addr = '0;

    function automatic int nxt_row(input int r);
        return (r + 1) % (1 << AW);
    endfunction

    task automatic ck(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %m: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (en) begin
            if (prev_ras && !ras_n) begin
                if (pulses > 0) ck(high_len >= PRE, "R4 precharge", high_len, PRE);
                ck(bus_req, "R3 req at fall", bus_req, 1);
                if (CBR) begin
                    ck(lead >= LEAD, "R5 cas lead", lead, LEAD);
                    ck(we_n, "R5 we_n high", we_n, 1);
                end else begin
                    ck(cas_n, "R6 cas high", cas_n, 1);
                    ck(int'(addr) == exp_row, "R6 row addr", int'(addr), exp_row);
                    exp_row = nxt_row(exp_row);
                end
                fall_addr = addr;
                pulses++;
                low_len = 0;
                bad = 1'b0;
            end
            if (!ras_n) begin
                low_len++;
                if (CBR && cas_n) bad = 1'b1;
                if (!CBR && (addr != fall_addr)) bad = 1'b1;
                if (!we_n || !bus_req) bad = 1'b1;
            end
            if (!prev_ras && ras_n) begin
                ck(low_len == LOW, "R4 ras width", low_len, LOW);
                ck(!bad, CBR ? "R5 cas/we during pulse" : "R6 addr stable", bad, 0);
                high_len = 0;
            end
            if (ras_n) high_len++;
            if (ras_n && !cas_n) lead++; else lead = 0;
            prev_ras = ras_n;
        end
    end
endmodule

module sim_dref_seq;
    localparam int P_PAUSE = 200;
    localparam int P_INIT  = 8;
    localparam int P_INTV  = 60;
    localparam int P_IDLE  = 400;
    localparam int P_LOW   = 6;
    localparam int P_PRE   = 5;
    localparam int P_LEAD  = 1;
    localparam int P_OVR   = 2;
    localparam int P_ROW   = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, en = 1'b0, hold_off = 1'b0, ext_ras_n = 1'b1;
    logic gnt0 = 1'b0, gnt1 = 1'b0;
    logic rdy0, req0, drv0, ras0, cas0, we0, ovr0;
    logic rdy1, req1, drv1, ras1, cas1, we1, ovr1;
    logic [10:0] addr0;
    logic [P_ROW-1:0] addr1;

    int checks = 0, fails = 0;

    dref_seq #(.PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .INTERVAL_CYC(P_INTV),
               .IDLE_LIMIT(P_IDLE), .RAS_LOW_CYC(P_LOW), .RAS_PRE_CYC(P_PRE),
               .CAS_LEAD_CYC(P_LEAD), .OVR_LIMIT(P_OVR), .ROW_W(11), .USE_CBR(1'b1))
    u0 (.clk(clk), .rst_n(rst_n), .bus_gnt(gnt0), .ext_ras_n(ext_ras_n),
        .ready(rdy0), .bus_req(req0), .drive_en(drv0), .ras_n(ras0), .cas_n(cas0),
        .we_n(we0), .addr(addr0), .ovr_err(ovr0));

    dref_seq #(.PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .INTERVAL_CYC(P_INTV),
               .IDLE_LIMIT(P_IDLE), .RAS_LOW_CYC(P_LOW), .RAS_PRE_CYC(P_PRE),
               .CAS_LEAD_CYC(P_LEAD), .OVR_LIMIT(P_OVR), .ROW_W(P_ROW), .USE_CBR(1'b0))
    u1 (.clk(clk), .rst_n(rst_n), .bus_gnt(gnt1), .ext_ras_n(ext_ras_n),
        .ready(rdy1), .bus_req(req1), .drive_en(drv1), .ras_n(ras1), .cas_n(cas1),
        .we_n(we1), .addr(addr1), .ovr_err(ovr1));

    sim_dref_mon #(.CBR(1'b1), .AW(11), .LOW(P_LOW), .PRE(P_PRE), .LEAD(P_LEAD))
    m0 (.clk(clk), .en(en), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .addr(addr0), .bus_req(req0));

    sim_dref_mon #(.CBR(1'b0), .AW(P_ROW), .LOW(P_LOW), .PRE(P_PRE), .LEAD(P_LEAD))
    m1 (.clk(clk), .en(en), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .addr(addr1), .bus_req(req1));

    task automatic ck(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d",
                 checks + m0.checks + m1.checks, fails + m0.fails + m1.fails);
        $finish;
    endtask

    // Granters with random latency; a grant once given is kept until req drops (R3)
    initial begin
        int lat0 = 1, lat1 = 2;
        forever begin
            @(negedge clk);
            if (!req0) begin gnt0 = 1'b0; lat0 = $urandom_range(0, 3); end
            else if (!gnt0 && !hold_off) begin
                if (lat0 == 0) gnt0 = 1'b1; else lat0--;
            end
            if (!req1) begin gnt1 = 1'b0; lat1 = $urandom_range(0, 3); end
            else if (!gnt1 && !hold_off) begin
                if (lat1 == 0) gnt1 = 1'b1; else lat1--;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    task automatic wait_ready(input string rq, input int p0s, input int p1s);
        bit s0 = 0, s1 = 0;
        for (int t = 0; t < 3000 && !(s0 && s1); t++) begin
            @(negedge clk);
            if (!s0 && rdy0) begin s0 = 1; ck(m0.pulses - p0s == P_INIT, rq, m0.pulses - p0s, P_INIT); end
            if (!s1 && rdy1) begin s1 = 1; ck(m1.pulses - p1s == P_INIT, rq, m1.pulses - p1s, P_INIT); end
        end
        ck(s0 && s1, {rq, " ready reached"}, s0 && s1, 1);
    endtask

    task automatic rate_window();
        int a0 = m0.pulses, a1 = m1.pulses;
        repeat (10 * P_INTV) @(negedge clk);
        ck((m0.pulses - a0) >= 9 && (m0.pulses - a0) <= 11, "R7 rate cbr", m0.pulses - a0, 10);
        ck((m1.pulses - a1) >= 9 && (m1.pulses - a1) <= 11, "R7 rate ras-only", m1.pulses - a1, 10);
    endtask

    initial begin
        bit drop;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        en    = 1'b1;
        @(negedge clk);
        // R1 reset state
        ck(!rdy0 && !rdy1, "R1 ready low", rdy0 | rdy1, 0);
        ck(!req0 && !req1 && !drv0 && !drv1, "R1 no request", req0 | req1 | drv0 | drv1, 0);
        ck(ras0 && cas0 && ras1 && cas1 && !ovr0 && !ovr1, "R1 strobes idle",
           {ras0, cas0, ras1, cas1}, 4'hf);
        repeat (P_PAUSE - 5) @(negedge clk);
        // R1 nothing during pause
        ck(m0.pulses == 0 && m1.pulses == 0, "R1 no pulse in pause", m0.pulses + m1.pulses, 0);
        ck(!req0 && !req1 && !rdy0 && !rdy1, "R1 idle at pause end", req0 | req1, 0);
        // R2 warm-up count (ras-only row counter wraps: R6)
        wait_ready("R2 init pulses", 0, 0);
        ck(!ovr0 && !ovr1, "R8 no overrun after init", ovr0 | ovr1, 0);
        rate_window();

        // R8 / R9 starvation
        hold_off = 1'b1;
        repeat (100) @(negedge clk);
        ck(!ovr0 && !ovr1, "R8 overrun not yet", ovr0 + ovr1, 0);
        repeat (100) @(negedge clk);
        ck(ovr0 && ovr1, "R8 overrun raised", ovr0 + ovr1, 2);
        ck(rdy0 && rdy1, "R9 still ready", rdy0 + rdy1, 2);
        repeat (260) @(negedge clk);
        ck(!rdy0 && !rdy1, "R9 ready dropped", rdy0 + rdy1, 0);
        hold_off = 1'b0;
        wait_ready("R9 re-init pulses", m0.pulses, m1.pulses);
        ck(!ovr0 && !ovr1, "R8 overrun cleared", ovr0 + ovr1, 0);
        rate_window();

        // R10 controller activity keeps the part alive
        hold_off = 1'b1;
        drop = 0;
        for (int t = 0; t < 700; t++) begin
            ext_ras_n = !((t % 100) >= 90 && (t % 100) < 93);
            @(negedge clk);
            if (!rdy0 || !rdy1) drop = 1;
        end
        ext_ras_n = 1'b1;
        ck(!drop, "R10 ready kept by ext ras", drop, 0);
        ck(ovr0 && ovr1, "R8 overrun while starved", ovr0 + ovr1, 2);
        hold_off = 1'b0;
        repeat (100) @(negedge clk);
        ck(!ovr0 && !ovr1 && rdy0 && rdy1, "R8 overrun cleared after service",
           ovr0 + ovr1, 0);

        // Random short starvations never trigger re-init (R9) and recover (R8)
        for (int k = 0; k < 6; k++) begin
            int len = $urandom_range(40, 150);
            hold_off = 1'b1;
            repeat (len) @(negedge clk);
            hold_off = 1'b0;
            ck(rdy0 && rdy1, "R9 no false re-init", rdy0 + rdy1, 2);
            repeat (80) @(negedge clk);
            ck(!ovr0 && !ovr1, "R8 recovered", ovr0 + ovr1, 0);
        end
        rate_window();
        report();
    end
endmodule